// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block gathers a configurable number of interrupt request lines (up to 32) and turns them into one request for a processor. Each line is fixed at build time as edge-triggered or level-triggered. Every line passes through a two-flop synchronizer and is then captured into a status bit. Software enables lines one by one, acknowledges the lines it has serviced, and reads back which enabled line is pending.

A small register bus reaches eight 32-bit word registers. The enable register can be written whole. It can also be changed through separate write-one-to-set and write-one-to-clear registers, so software needs no read-modify-write. A vector register returns the lowest-numbered line that is both latched and enabled. When no such line exists it returns all ones. A two-bit master register gates the processor request.

The bus is addressed by word index. A write takes effect on the clock edge where `bus_wr_i` is high. Read data is combinational from the selected register.

Top module: `interrupt_ctrl`

## Requirements
- R1: After reset the status, enable and master bits are all 0, `irq_o` is low, and the vector register reads 0xFFFFFFFF.
- R2: The word index selects the register: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. Writes to status, pending and vector change nothing. Acknowledge, set-enable and clear-enable read as 0.
- R3: Writing the set-enable register sets each enable bit whose written bit is 1. Enable bits whose written bit is 0 keep their value.
- R4: Writing the clear-enable register clears each enable bit whose written bit is 1. Enable bits whose written bit is 0 keep their value.
- R5: Writing the enable register replaces all enable bits. Enable bits at or above the number of implemented lines always read 0.
- R6: An edge line latches its status bit on a rising edge of its synchronized input. The bit appears on the third clock edge after the input rises. It stays set after the input falls, until it is acknowledged. A line held high does not latch again after an acknowledge.
- R7: A level line sets its status bit while its synchronized input is high. An acknowledge while the input is still high leaves the bit set. An acknowledge after the input has fallen clears it.
- R8: Writing the acknowledge register clears the status bit of each line whose written bit is 1, unless that line re-triggers. Written 0 bits leave status untouched. Writing 0xFFFFFFFF clears every bit that is not being re-triggered.
- R9: The pending register reads the bitwise AND of status and enable.
- R10: The vector register reads the index of the lowest-numbered pending bit, zero-extended to 32 bits. It reads 0xFFFFFFFF when no bit is pending.
- R11: Bit 0 of the master register is the core enable and bit 1 is the request enable. `irq_o` is high only when both bits are 1 and at least one bit is pending. The master register reads back both bits.
- R12: The mode mask bit for line i selects edge capture when 1 and level capture when 0. Mask bits at or above the line count have no effect. Status and pending bits for unimplemented lines read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | NUM_IN | Asynchronous interrupt request lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_word_i | input | 3 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
The bench checks an acknowledge of a level line whose source is still high; a design that cleared the bit outright would lose that request. It holds an edge line high across an acknowledge and drops an edge line before servicing it. A level-style edge line would then either fire again or lose the event. It checks that the vector chooses the lowest of two pending lines and reads all ones when status is set but not enabled. An encoder built on status alone, or a missing all-ones default, would show there. It also walks the master register through every two-bit value and writes the enable register with every bit set. An OR-gated request, or enable bits kept for missing lines, would be caught.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int REG_W    = 32;
    localparam int SEL_W    = 3;
    localparam int SYNC_LEN = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_ACK    = 3'd3,
        SEL_SETEN  = 3'd4,
        SEL_CLREN  = 3'd5,
        SEL_VECTOR = 3'd6,
        SEL_MASTER = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic req_en;   // bit 1
        logic core_en;  // bit 0
    } master_t;

    typedef struct packed {
        logic en_load;
        logic en_set;
        logic en_clr;
        logic ack;
        logic master;
    } wr_strobe_t;

    localparam logic [REG_W-1:0] NO_LINE = '1;

    function automatic wr_strobe_t decode_write(input logic wr, input reg_sel_e sel);
        wr_strobe_t s;
        s         = '0;
        s.en_load = wr && (sel == SEL_ENABLE);
        s.en_set  = wr && (sel == SEL_SETEN);
        s.en_clr  = wr && (sel == SEL_CLREN);
        s.ack     = wr && (sel == SEL_ACK);
        s.master  = wr && (sel == SEL_MASTER);
        return s;
    endfunction

endpackage

// File: rtl/intc_line_capture.sv
module intc_line_capture #(
    parameter bit EDGE_MODE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic src_i,
    input  logic ack_i,
    output logic status_o
);
    import intc_pkg::*;

    logic [SYNC_LEN-1:0] sync_q;
    logic                last_q;
    logic                hit;
    logic                status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], src_i};
            last_q <= sync_q[SYNC_LEN-1];
        end
    end

    generate
        if (EDGE_MODE) begin : g_edge
            assign hit = sync_q[SYNC_LEN-1] & ~last_q;
        end else begin : g_level
            assign hit = sync_q[SYNC_LEN-1];
            // R7: acknowledge of a line still high leaves it set
            assert_level_reassert_R7: assert property (@(posedge clk) disable iff (rst)
                (ack_i && sync_q[SYNC_LEN-1]) |=> status_o);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) status_q <= 1'b0;
        else     status_q <= (status_q & ~ack_i) | hit;
    end

    assign status_o = status_q;

    // R8: a latched bit is only removed by an acknowledge
    assert_status_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (status_o && !ack_i) |=> status_o);

endmodule

// File: rtl/intc_enable_bank.sv
module intc_enable_bank #(
    parameter int NUM_IN = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  intc_pkg::wr_strobe_t strobe_i,
    input  logic [NUM_IN-1:0]   wdata_i,
    output logic [NUM_IN-1:0]   en_o
);
    logic [NUM_IN-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (strobe_i.en_load) begin
            en_q <= wdata_i;
        end else if (strobe_i.en_set) begin
            en_q <= en_q | wdata_i;
        end else if (strobe_i.en_clr) begin
            en_q <= en_q & ~wdata_i;
        end
    end

    assign en_o = en_q;

    // R3: every written one is set afterwards
    assert_set_enable_R3: assert property (@(posedge clk) disable iff (rst)
        strobe_i.en_set |=> ((en_o & $past(wdata_i)) == $past(wdata_i)));
    // R4: every written one is cleared afterwards
    assert_clear_enable_R4: assert property (@(posedge clk) disable iff (rst)
        strobe_i.en_clr |=> ((en_o & $past(wdata_i)) == '0));

endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
    parameter int NUM_IN = 32
) (
    input  logic [NUM_IN-1:0]          pend_i,
    output logic [intc_pkg::REG_W-1:0] vec_o
);
    import intc_pkg::*;

    always_comb begin
        vec_o = NO_LINE;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (pend_i[i]) vec_o = REG_W'(i);
        end
    end

endmodule

// File: rtl/interrupt_ctrl.sv
module interrupt_ctrl #(
    parameter int          NUM_IN    = 32,
    parameter logic [31:0] EDGE_MASK = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_src_i,
    input  logic              bus_wr_i,
    input  logic [2:0]        bus_word_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);
    import intc_pkg::*;

    reg_sel_e          sel;
    wr_strobe_t        strobe;
    logic [NUM_IN-1:0] status;
    logic [NUM_IN-1:0] enable;
    logic [NUM_IN-1:0] pend;
    logic [NUM_IN-1:0] ack_bits;
    logic [REG_W-1:0]  status_w;
    logic [REG_W-1:0]  enable_w;
    logic [REG_W-1:0]  pend_w;
    logic [REG_W-1:0]  vector;
    master_t           master_q;

    assign sel      = reg_sel_e'(bus_word_i);
    assign strobe   = decode_write(bus_wr_i, sel);
    assign ack_bits = strobe.ack ? bus_wdata_i[NUM_IN-1:0] : '0;

    generate
        for (genvar i = 0; i < NUM_IN; i++) begin : g_line
            intc_line_capture #(.EDGE_MODE(EDGE_MASK[i])) u_cap (
                .clk      (clk),
                .rst      (rst),
                .src_i    (irq_src_i[i]),
                .ack_i    (ack_bits[i]),
                .status_o (status[i])
            );
        end
    endgenerate

    intc_enable_bank #(.NUM_IN(NUM_IN)) u_en (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe),
        .wdata_i  (bus_wdata_i[NUM_IN-1:0]),
        .en_o     (enable)
    );

    assign pend = status & enable;

    intc_prio_enc #(.NUM_IN(NUM_IN)) u_enc (
        .pend_i (pend),
        .vec_o  (vector)
    );

    always_ff @(posedge clk) begin
        if (rst)              master_q <= '0;
        else if (strobe.master) master_q <= master_t'(bus_wdata_i[1:0]);
    end

    assign irq_o = master_q.core_en & master_q.req_en & (|pend);

    always_comb begin
        status_w = '0;
        enable_w = '0;
        pend_w   = '0;
        status_w[NUM_IN-1:0] = status;
        enable_w[NUM_IN-1:0] = enable;
        pend_w[NUM_IN-1:0]   = pend;
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS: bus_rdata_o = status_w;
            SEL_PEND:   bus_rdata_o = pend_w;
            SEL_ENABLE: bus_rdata_o = enable_w;
            SEL_VECTOR: bus_rdata_o = vector;
            SEL_MASTER: bus_rdata_o = {{(REG_W-2){1'b0}}, master_q};
            default:    bus_rdata_o = '0;
        endcase
    end

    // R11: a master write that is not both bits drops the request next cycle
    assert_master_gate_R11: assert property (@(posedge clk) disable iff (rst)
        (strobe.master && bus_wdata_i[1:0] != 2'b11) |=> !irq_o);
    // R10: no pending line gives the all-ones vector
    assert_vector_none_R10: assert property (@(posedge clk) disable iff (rst)
        (pend_w == '0) |-> (vector == NO_LINE));
    // R10: the vector names a pending line with nothing pending below it
    assert_vector_lowest_R10: assert property (@(posedge clk) disable iff (rst)
        (pend_w != '0) |-> (((pend_w >> vector) & 32'd1) == 32'd1
                            && (pend_w & ((32'd1 << vector) - 32'd1)) == '0));

endmodule

// File: tb/interrupt_ctrl_test.sv
module interrupt_ctrl_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 12;
    localparam logic [31:0] EMASK      = 32'hFFFF_F0F0; // lines 4..7 edge, bits >= 12 ignored

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src = '0;
    logic         wr = 1'b0;
    logic [2:0]   word = 3'd0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [2:0]  word;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    interrupt_ctrl #(.NUM_IN(N), .EDGE_MASK(EMASK)) uut (
        .clk(clk), .rst(rst), .irq_src_i(src), .bus_wr_i(wr),
        .bus_word_i(word), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    // monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {31'd0, irq} : rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_reg(input logic [2:0] w, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        word = w;
        it.is_irq = 1'b0; it.word = w; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.is_irq = 1'b1; it.word = 3'd0; it.exp = {31'd0, e}; it.tag = tag;
        sb.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic write_reg(input logic [2:0] w, input logic [31:0] d);
        @(posedge clk); #1;
        wr = 1'b1; word = w; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0; wdata = '0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        expect_reg(3'd0, 32'h0, "R1 status");
        expect_reg(3'd2, 32'h0, "R1 enable");
        expect_reg(3'd7, 32'h0, "R1 master");
        expect_reg(3'd6, 32'hFFFF_FFFF, "R1 vector");
        expect_irq(1'b0, "R1 irq");

        // R5 / R12 direct enable write
        write_reg(3'd2, 32'hFFFF_FFFF);
        expect_reg(3'd2, 32'h0000_0FFF, "R5 enable unimplemented bits zero");
        write_reg(3'd2, 32'h0);
        expect_reg(3'd2, 32'h0, "R5 enable cleared");

        // R3 / R4 set and clear enables
        write_reg(3'd4, 32'h5);
        expect_reg(3'd2, 32'h5, "R3 set-enable");
        write_reg(3'd4, 32'h30);
        expect_reg(3'd2, 32'h35, "R3 set keeps others");
        write_reg(3'd5, 32'h14);
        expect_reg(3'd2, 32'h21, "R4 clear-enable");
        expect_reg(3'd4, 32'h0, "R2 set-enable reads zero");

        // R7 / R9 / R10 level line 2 not enabled
        src[2] = 1'b1;
        settle();
        expect_reg(3'd0, 32'h4, "R7 level latch");
        expect_reg(3'd1, 32'h0, "R9 pending masked");
        expect_reg(3'd6, 32'hFFFF_FFFF, "R10 vector none");
        write_reg(3'd4, 32'h4);
        expect_reg(3'd1, 32'h4, "R9 pending");
        expect_reg(3'd6, 32'h2, "R10 vector line 2");

        // R11 master gating
        expect_irq(1'b0, "R11 master 00");
        write_reg(3'd7, 32'h1);
        expect_irq(1'b0, "R11 master 01");
        write_reg(3'd7, 32'h2);
        expect_irq(1'b0, "R11 master 10");
        write_reg(3'd7, 32'h3);
        expect_irq(1'b1, "R11 master 11");
        expect_reg(3'd7, 32'h3, "R11 master readback");

        // R7 ack while high, then after low
        write_reg(3'd3, 32'h4);
        expect_reg(3'd0, 32'h4, "R7 ack while high keeps bit");
        src[2] = 1'b0;
        settle();
        expect_reg(3'd0, 32'h4, "R7 held after fall");
        write_reg(3'd3, 32'h4);
        expect_reg(3'd0, 32'h0, "R7 ack after fall clears");
        expect_irq(1'b0, "R11 nothing pending");

        // R6 edge line 5 pulse
        src[5] = 1'b1;
        settle();
        expect_reg(3'd0, 32'h20, "R6 edge latch");
        src[5] = 1'b0;
        settle();
        expect_reg(3'd0, 32'h20, "R6 edge held after fall");
        src[9] = 1'b1;
        settle();
        write_reg(3'd4, 32'h200);
        expect_reg(3'd1, 32'h220, "R9 two pending");
        expect_reg(3'd6, 32'h5, "R10 lowest wins");
        write_reg(3'd3, 32'h20);
        expect_reg(3'd0, 32'h200, "R8 ack clears edge only");
        expect_reg(3'd6, 32'h9, "R10 next line");
        expect_irq(1'b1, "R11 irq with line 9");
        write_reg(3'd3, 32'hFFFF_FFFF);
        expect_reg(3'd0, 32'h200, "R8 ack all with level high");
        src[9] = 1'b0;
        settle();
        write_reg(3'd3, 32'hFFFF_FFFF);
        expect_reg(3'd0, 32'h0, "R8 ack all clears");

        // R2 writes to read-only registers ignored
        write_reg(3'd0, 32'hFFFF_FFFF);
        write_reg(3'd6, 32'h0);
        write_reg(3'd1, 32'hFFFF_FFFF);
        expect_reg(3'd0, 32'h0, "R2 status write ignored");
        expect_reg(3'd6, 32'hFFFF_FFFF, "R2 vector write ignored");
        expect_reg(3'd2, 32'h225, "R2 enable untouched");

        // R6 edge held high does not re-latch
        src[6] = 1'b1;
        settle();
        expect_reg(3'd0, 32'h40, "R6 edge line 6");
        write_reg(3'd3, 32'h40);
        settle();
        expect_reg(3'd0, 32'h0, "R6 no relatch while high");

        // R8 zero bits untouched
        src[6] = 1'b0;
        settle();
        src[6] = 1'b1;
        src[0] = 1'b1;
        settle();
        expect_reg(3'd0, 32'h41, "R8 two set");
        write_reg(3'd3, 32'h40);
        expect_reg(3'd0, 32'h1, "R8 zero bit untouched");
        expect_reg(3'd6, 32'h0, "R10 vector line 0");
        write_reg(3'd7, 32'h1);
        expect_irq(1'b0, "R11 master dropped");

        // R12 mask bits beyond line count ignored, lines 8..11 are level
        src[11] = 1'b1;
        settle();
        write_reg(3'd3, 32'h800);
        expect_reg(3'd0, 32'h801, "R12 line 11 level");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule